// File: doc/BRIEF.md
# RTC Register Bank and Update Sequencer

This block is the software-visible face of a real-time clock. A two-address bus port gives access through an index register to 128 bytes of storage. The first fourteen bytes hold the running time, three alarm bytes, two control registers, a flag register and a status register. The remaining bytes are plain scratch storage. The block enforces the side effects of each access. These are read-only bits, a register that clears itself when read, a freeze bit that stops time updates, and a reload of the running time whenever software rewrites the time.

Once per second a tick starts an update, but only if the oscillator-control field holds the run code. The block raises update-in-progress, asks the external calendar to advance, and waits a set number of sub-second strobes. It then copies the new time into the registers, compares the time with the alarm bytes and flags the end of the update. The calendar arithmetic and the periodic-rate generator live outside and connect through ports. Bus accesses complete in the cycle they are presented. There is no ready signal and no back-pressure: the read data is valid combinationally while `bus_rd` is high, and the read side effect takes place at the next clock edge.

Top module: `rtc_regbank_seq`

## Requirements
- R1: A write to address 0 latches bits 6:0 of the data as the index. Reads and writes at address 1 access the indexed byte. Reading address 0 returns 0xFF. Bytes at indexes 14..127 read back what was last written.
- R2: Bit 7 of control register A (index 10, update-in-progress) is read-only. A write to A replaces bits 6:0 and keeps bit 7.
- R3: Writing control register B (index 11) with bit 7 (freeze) set stores the value with bit 4 (update-end enable) forced to 0, and clears the update-in-progress bit.
- R4: `cal_load` pulses one cycle after either of two writes: a write of a time register (index 0, 2, 4, 6, 7, 8 or 9) while freeze is low, or a write of B with freeze low when freeze was high. A time write made while freeze is high gives no pulse. `cal_set_time` carries the seven time bytes, with index 0 in bits 7:0 and index 9 in bits 55:48.
- R5: Writes to index 12 (flags, register C) and index 13 (status, register D) are ignored. Reading C returns its value, then clears it to 0x00 and drops `irq`.
- R6: A second tick starts an update, with a `cal_step` pulse, only when bits 6:4 of A equal 010. For any other code the tick is dropped.
- R7: At the start of an update, bit 7 of A is set unless freeze is high. On the DELAY_TICKS-th `sub_tick`, the `cal_now` bytes are copied into the time registers (unless freeze is high) and bit 7 of A is cleared.
- R8: At the end of an update with B bit 5 (alarm enable) set, the alarm bytes at indexes 1, 3 and 5 are compared with the seconds, minutes and hours of `cal_now`. An alarm byte with bits 7:6 = 11 matches any value. A full match sets bits 7 and 5 of C.
- R9: Every completed update sets C bit 4. If B bit 4 is set, it also sets C bit 7.
- R10: After `rst_n`, A=0x26, B=0x02, C=0x00 and D=0x80.
- R11: A `sys_rst` pulse clears B bits 6, 5 and 3 and C bits 7:4, and drops `irq`.
- R12: A `per_tick` pulse sets C bits 7 and 6 when B bit 6 (periodic enable) is set. It has no effect otherwise.
- R13: `irq` equals C bit 7. It stays high from the event that sets the bit until C is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sys_rst | input | 1 | Synchronous system reset of enables and flags |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 1 | 0 = index register, 1 = data window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sec_tick | input | 1 | One-second tick, one cycle pulse |
| sub_tick | input | 1 | 32.768 kHz strobe, one cycle pulse |
| cal_step | output | 1 | Asks the calendar to advance one second |
| cal_load | output | 1 | Asks the calendar to load `cal_set_time` |
| cal_set_time | output | 56 | Time register contents, index 0 in the low byte |
| cal_now | input | 56 | Current calendar time, same byte order |
| per_tick | input | 1 | Event from the periodic-rate generator |
| per_rate | output | 4 | Rate code, A bits 3:0 |
| per_int_en | output | 1 | Periodic interrupt enable, B bit 6 |
| per_sqw_en | output | 1 | Square-wave enable, B bit 3 |
| irq | output | 1 | Level interrupt request |

## Verification
The oscillator field is swept through all eight codes. Only the run code may produce an update-in-progress bit, a `cal_step` pulse and an update-ended flag, so this sweep separates the gating from the sequencer. The alarm compare is tried with all 27 mixes of exact, wrong and don't-care bytes across the three fields. This tells a per-field miss from a don't-care match and shows that any single miss blocks the alarm. The scratch area is swept with an index-dependent pattern, and the index register is written with bit 7 set, to show address decoding and the 7-bit latch. The freeze bit is tried both ways around a full update, to separate the copy from the reload pulse.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Core register indexes
  localparam int unsigned IX_A     = 10;
  localparam int unsigned IX_B     = 11;
  localparam int unsigned IX_C     = 12;
  localparam int unsigned IX_D     = 13;
  localparam int unsigned N_CORE   = 14;
  localparam int unsigned N_TIME   = 7;
  localparam int unsigned N_ALARM  = 3;

  // Bit positions
  localparam int unsigned A_UIP  = 7;
  localparam int unsigned B_SET  = 7;
  localparam int unsigned B_PIE  = 6;
  localparam int unsigned B_AIE  = 5;
  localparam int unsigned B_UIE  = 4;
  localparam int unsigned B_SQWE = 3;
  localparam int unsigned C_IRQF = 7;
  localparam int unsigned C_PF   = 6;
  localparam int unsigned C_AF   = 5;
  localparam int unsigned C_UF   = 4;

  localparam logic [2:0] OSC_RUN = 3'b010;
  localparam logic [7:0] A_INIT  = 8'h26;
  localparam logic [7:0] B_INIT  = 8'h02;
  localparam logic [7:0] C_INIT  = 8'h00;
  localparam logic [7:0] D_CONST = 8'h80;
  localparam logic [7:0] M_UIE   = 8'h10;

  // {hit, slot}: position of an index among the time bytes
  function automatic logic [3:0] time_slot(int unsigned ix);
    case (ix)
      0: return 4'b1000;
      2: return 4'b1001;
      4: return 4'b1010;
      6: return 4'b1011;
      7: return 4'b1100;
      8: return 4'b1101;
      9: return 4'b1110;
      default: return 4'b0000;
    endcase
  endfunction

  // {hit, slot}: position of an index among the alarm bytes
  function automatic logic [2:0] alarm_slot(int unsigned ix);
    case (ix)
      1: return 3'b100;
      3: return 3'b101;
      5: return 3'b110;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
  import rtc_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       sub_tick,
  input  logic [2:0] osc_code,
  output logic       start_o,
  output logic       finish_o,
  output logic       busy_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    start_o  = !busy_q && sec_tick && (osc_code == OSC_RUN);
    finish_o = busy_q && sub_tick && (cnt_q == LAST);
    busy_o   = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (finish_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && sub_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: a tick under a non-run oscillator code leaves the sequencer idle
  a_r6_osc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && sec_tick && osc_code != OSC_RUN) |=> !busy_q);
  // R7: the delay counter never passes its last value
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
  // R7: finishing returns to idle
  a_r7_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !busy_q);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned N_FIELDS = 3
) (
  input  logic [N_FIELDS*8-1:0] alarm_i,
  input  logic [N_FIELDS*8-1:0] now_i,
  output logic                  hit_o
);
  logic [N_FIELDS-1:0] ok;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    logic [7:0] al;
    logic [7:0] nw;
    assign al = alarm_i[g*8 +: 8];
    assign nw = now_i[g*8 +: 8];
    assign ok[g] = (al[7:6] == 2'b11) || (al == nw);
  end

  assign hit_o = &ok;
endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/rtc_regbank_seq.sv
module rtc_regbank_seq
  import rtc_pkg::*;
#(
  parameter int unsigned IDX_W       = 7,
  parameter int unsigned DELAY_TICKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        sec_tick,
  input  logic        sub_tick,
  output logic        cal_step,
  output logic        cal_load,
  output logic [55:0] cal_set_time,
  input  logic [55:0] cal_now,
  input  logic        per_tick,
  output logic [3:0]  per_rate,
  output logic        per_int_en,
  output logic        per_sqw_en,
  output logic        irq
);
  localparam logic [IDX_W-1:0] IXA    = IDX_W'(IX_A);
  localparam logic [IDX_W-1:0] IXB    = IDX_W'(IX_B);
  localparam logic [IDX_W-1:0] IXC    = IDX_W'(IX_C);
  localparam logic [IDX_W-1:0] IXD    = IDX_W'(IX_D);
  localparam logic [IDX_W-1:0] IXCORE = IDX_W'(N_CORE);

  logic [IDX_W-1:0]        idx_q;
  logic [N_TIME-1:0][7:0]  time_q;
  logic [N_ALARM-1:0][7:0] al_q;
  logic [7:0]              reg_a, reg_b, reg_c;
  logic                    load_q;

  logic wr_idx, wr_dat, rd_dat;
  logic [3:0] ts;
  logic [2:0] asel;
  logic seq_start, seq_finish, seq_busy;
  logic alarm_hit;
  logic [7:0] scr_rd;

  always_comb begin
    wr_idx = bus_wr && !bus_addr;
    wr_dat = bus_wr && bus_addr;
    rd_dat = bus_rd && bus_addr;
    ts     = time_slot(int'(idx_q));
    asel   = alarm_slot(int'(idx_q));
  end

  rtc_upd_seq #(.DELAY_TICKS(DELAY_TICKS)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .sub_tick (sub_tick),
    .osc_code (reg_a[6:4]),
    .start_o  (seq_start),
    .finish_o (seq_finish),
    .busy_o   (seq_busy)
  );

  rtc_alarm_cmp #(.N_FIELDS(N_ALARM)) i_alarm (
    .alarm_i (al_q),
    .now_i   (cal_now[N_ALARM*8-1:0]),
    .hit_o   (alarm_hit)
  );

  rtc_scratch #(.IDX_W(IDX_W)) i_scratch (
    .clk   (clk),
    .we    (wr_dat && (idx_q >= IXCORE)),
    .idx   (idx_q),
    .wdata (bus_wdata),
    .rdata (scr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      time_q <= '0;
      al_q   <= '0;
      reg_a  <= A_INIT;
      reg_b  <= B_INIT;
      reg_c  <= C_INIT;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      // clear on read first, so that a flag set in the same cycle survives
      if (rd_dat && idx_q == IXC) reg_c <= 8'h00;
      if (per_tick && reg_b[B_PIE]) begin
        reg_c[C_IRQF] <= 1'b1;
        reg_c[C_PF]   <= 1'b1;
      end
      if (seq_start && !reg_b[B_SET]) reg_a[A_UIP] <= 1'b1;
      if (seq_finish) begin
        if (!reg_b[B_SET]) time_q <= cal_now;
        if (reg_b[B_AIE] && alarm_hit) begin
          reg_c[C_IRQF] <= 1'b1;
          reg_c[C_AF]   <= 1'b1;
        end
        reg_c[C_UF] <= 1'b1;
        if (reg_b[B_UIE]) reg_c[C_IRQF] <= 1'b1;
        reg_a[A_UIP] <= 1'b0;
      end
      if (wr_idx) idx_q <= bus_wdata[IDX_W-1:0];
      if (wr_dat) begin
        if (ts[3]) begin
          time_q[ts[2:0]] <= bus_wdata;
          if (!reg_b[B_SET]) load_q <= 1'b1;
        end else if (asel[2]) begin
          al_q[asel[1:0]] <= bus_wdata;
        end else if (idx_q == IXA) begin
          reg_a[6:0] <= bus_wdata[6:0];
        end else if (idx_q == IXB) begin
          if (bus_wdata[B_SET]) begin
            reg_a[A_UIP] <= 1'b0;
            reg_b        <= bus_wdata & ~M_UIE;
          end else begin
            reg_b <= bus_wdata;
            if (reg_b[B_SET]) load_q <= 1'b1;
          end
        end
      end
      if (sys_rst) begin
        reg_b[B_PIE]  <= 1'b0;
        reg_b[B_AIE]  <= 1'b0;
        reg_b[B_SQWE] <= 1'b0;
        reg_c[7:4]    <= 4'h0;
      end
    end
  end

  always_comb begin
    if (!bus_addr)       bus_rdata = 8'hFF;
    else if (ts[3])      bus_rdata = time_q[ts[2:0]];
    else if (asel[2])    bus_rdata = al_q[asel[1:0]];
    else if (idx_q == IXA) bus_rdata = reg_a;
    else if (idx_q == IXB) bus_rdata = reg_b;
    else if (idx_q == IXC) bus_rdata = reg_c;
    else if (idx_q == IXD) bus_rdata = D_CONST;
    else                 bus_rdata = scr_rd;
  end

  assign cal_step     = seq_start;
  assign cal_load     = load_q;
  assign cal_set_time = time_q;
  assign per_rate     = reg_a[3:0];
  assign per_int_en   = reg_b[B_PIE];
  assign per_sqw_en   = reg_b[B_SQWE];
  assign irq          = reg_c[C_IRQF];

  // R2: a plain write to A leaves the update-in-progress bit alone
  a_r2_uip_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && idx_q == IXA && !seq_start && !seq_finish) |=> $stable(reg_a[A_UIP]));
  // R3: freeze write masks update-end enable and clears update-in-progress
  a_r3_set_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && idx_q == IXB && bus_wdata[B_SET]) |=> (!reg_b[B_UIE] && !reg_a[A_UIP]));
  // R4: leaving freeze requests a reload
  a_r4_unfreeze_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && idx_q == IXB && !bus_wdata[B_SET] && reg_b[B_SET]) |=> cal_load);
  // R5: reading the flags with no new event empties them and drops irq
  a_r5_c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && idx_q == IXC && !seq_finish && !(per_tick && reg_b[B_PIE])) |=> (reg_c == 8'h00 && !irq));
  // R9: every finished update leaves the update-ended flag set
  a_r9_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_finish && !sys_rst) |=> reg_c[C_UF]);
  // R11: system reset drops the request and the alarm/periodic enables
  a_r11_sysrst: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (!irq && !reg_b[B_PIE] && !reg_b[B_AIE]));
  // R7: update-in-progress is never set while the sequencer is idle after a finish
  a_r7_uip_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> !reg_a[A_UIP]);
endmodule

// File: tb/test_rtc_regbank_seq.sv
module test_rtc_regbank_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_rst = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        sec_tick = 1'b0, sub_tick = 1'b0;
  logic        cal_step, cal_load;
  logic [55:0] cal_set_time;
  logic [55:0] cal_now = 56'h0;
  logic        per_tick = 1'b0;
  logic [3:0]  per_rate;
  logic        per_int_en, per_sqw_en, irq;

  int n_chk = 0;
  int n_fail = 0;
  int n_step = 0;
  int n_load = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regbank_seq #(.IDX_W(7), .DELAY_TICKS(DELAY)) i_rtc_regbank_seq (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sec_tick(sec_tick), .sub_tick(sub_tick),
    .cal_step(cal_step), .cal_load(cal_load),
    .cal_set_time(cal_set_time), .cal_now(cal_now),
    .per_tick(per_tick), .per_rate(per_rate),
    .per_int_en(per_int_en), .per_sqw_en(per_sqw_en), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst_n && cal_step) n_step++;
    if (rst_n && cal_load) n_load++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] d);
    bwr(1'b0, ix); bwr(1'b1, d);
  endtask

  task automatic rreg(input logic [7:0] ix, output logic [7:0] v);
    bwr(1'b0, ix); brd(1'b1, v);
  endtask

  task automatic pulse_sec;
    @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic pulse_sub;
    @(negedge clk); sub_tick = 1'b1; @(negedge clk); sub_tick = 1'b0;
  endtask

  task automatic run_update;
    pulse_sec;
    repeat (DELAY) pulse_sub;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int s0, l0;
    logic [7:0] nb [3];
    logic [7:0] ab;
    bit all_ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: power-on values
    rreg(8'd10, v); chk("R10 A", v, 8'h26);
    rreg(8'd11, v); chk("R10 B", v, 8'h02);
    rreg(8'd12, v); chk("R10 C", v, 8'h00);
    rreg(8'd13, v); chk("R10 D", v, 8'h80);
    chk("R13 irq after reset", irq, 1'b0);

    // R1: even address reads 0xFF; scratch sweep
    brd(1'b0, v); chk("R1 even read", v, 8'hFF);
    for (int i = 14; i < 128; i++) wreg(8'(i), 8'((i * 7 + 3) & 8'hFF));
    for (int i = 14; i < 128; i++) begin
      rreg(8'(i), v); chk("R1 scratch", v, 8'((i * 7 + 3) & 8'hFF));
    end
    rreg(8'h80 | 8'd20, v); chk("R1 index 7-bit", v, 8'((20 * 7 + 3) & 8'hFF));

    // R2: UIP read-only under a write to A
    wreg(8'd10, 8'hA5); rreg(8'd10, v); chk("R2 A write keeps UIP=0", v, 8'h25);
    wreg(8'd10, 8'h26);
    pulse_sec;
    wreg(8'd10, 8'h26); rreg(8'd10, v); chk("R2 A write keeps UIP=1", v, 8'hA6);
    repeat (DELAY) pulse_sub;
    rreg(8'd12, v);

    // R5: C and D ignore writes
    wreg(8'd12, 8'hFF); rreg(8'd12, v); chk("R5 C write ignored", v, 8'h00);
    wreg(8'd13, 8'h00); rreg(8'd13, v); chk("R5 D write ignored", v, 8'h80);

    // R6: oscillator code sweep
    for (int osc = 0; osc < 8; osc++) begin
      s0 = n_step;
      wreg(8'd10, {1'b0, 3'(osc), 4'h6});
      pulse_sec;
      rreg(8'd10, v); chk("R6 UIP per osc code", v[7], (osc == 2));
      chk("R6 cal_step per osc code", n_step - s0, (osc == 2) ? 1 : 0);
      repeat (DELAY) pulse_sub;
      rreg(8'd12, v); chk("R6 UF per osc code", v, (osc == 2) ? 8'h10 : 8'h00);
    end
    wreg(8'd10, 8'h26);

    // R7: delay length and time copy
    cal_now = 56'h24_06_15_03_09_15_30;
    pulse_sec;
    repeat (DELAY - 1) pulse_sub;
    rreg(8'd10, v); chk("R7 UIP held before last strobe", v[7], 1'b1);
    pulse_sub;
    rreg(8'd10, v); chk("R7 UIP cleared at last strobe", v[7], 1'b0);
    rreg(8'd0, v); chk("R7 seconds copied", v, 8'h30);
    rreg(8'd9, v); chk("R7 year copied", v, 8'h24);
    rreg(8'd12, v);

    // R3 + R7: freeze masks UIE, blocks UIP and copy
    wreg(8'd11, 8'h92); rreg(8'd11, v); chk("R3 UIE masked under freeze", v, 8'h82);
    cal_now = 56'h25_07_16_04_10_16_31;
    pulse_sec;
    rreg(8'd10, v); chk("R7 no UIP under freeze", v[7], 1'b0);
    repeat (DELAY) pulse_sub;
    rreg(8'd0, v); chk("R7 no copy under freeze", v, 8'h30);
    rreg(8'd12, v); chk("R9 UF even under freeze", v, 8'h10);

    // R4: time write under freeze gives no load, leaving freeze loads
    l0 = n_load;
    wreg(8'd2, 8'h46); @(negedge clk);
    chk("R4 no load under freeze", n_load - l0, 0);
    wreg(8'd11, 8'h02); @(negedge clk);
    chk("R4 load on freeze exit", n_load - l0, 1);
    chk("R4 cal_set_time", cal_set_time, 56'h24_06_15_03_09_46_30);
    l0 = n_load;
    wreg(8'd4, 8'h11); @(negedge clk);
    chk("R4 load on time write", n_load - l0, 1);
    chk("R4 hour in cal_set_time", cal_set_time[23:16], 8'h11);

    // R3: freeze write clears a pending UIP
    pulse_sec;
    wreg(8'd11, 8'h82); rreg(8'd10, v); chk("R3 freeze clears UIP", v[7], 1'b0);
    repeat (DELAY) pulse_sub;
    wreg(8'd11, 8'h02);
    rreg(8'd12, v);

    // R8: alarm sweep over exact / wrong / don't-care per field
    cal_now = 56'h24_06_15_03_09_15_30;
    nb[0] = 8'h30; nb[1] = 8'h15; nb[2] = 8'h09;
    wreg(8'd11, 8'h22);
    for (int c = 0; c < 27; c++) begin
      all_ok = 1'b1;
      for (int f = 0; f < 3; f++) begin
        int m;
        m = (f == 0) ? (c % 3) : (f == 1) ? ((c / 3) % 3) : (c / 9);
        if (m == 0) ab = nb[f];
        else if (m == 1) begin ab = nb[f] + 8'd1; all_ok = 1'b0; end
        else ab = 8'hC0 | 8'(c);
        wreg(8'(2 * f + 1), ab);
      end
      run_update;
      chk("R8 irq on alarm", irq, all_ok);
      rreg(8'd12, v); chk("R8 C after alarm compare", v, all_ok ? 8'hB0 : 8'h10);
    end

    // R9 + R13: update-end interrupt held as a level until C is read
    wreg(8'd11, 8'h12);
    run_update;
    repeat (5) @(negedge clk);
    chk("R13 irq held high", irq, 1'b1);
    rreg(8'd12, v); chk("R9 C with UIE", v, 8'h90);
    chk("R5 irq dropped on read", irq, 1'b0);
    rreg(8'd12, v); chk("R5 C cleared by read", v, 8'h00);

    // R12: periodic event
    @(negedge clk); per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
    rreg(8'd12, v); chk("R12 no effect without PIE", v, 8'h00);
    wreg(8'd11, 8'h42);
    chk("R12 per_int_en", per_int_en, 1'b1);
    chk("R12 per_rate", per_rate, 4'h6);
    @(negedge clk); per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
    chk("R12 irq with PIE", irq, 1'b1);
    rreg(8'd12, v); chk("R12 C with PIE", v, 8'hC0);

    // R11: system reset
    wreg(8'd11, 8'h7A);
    chk("R11 sqw enable before", per_sqw_en, 1'b1);
    @(negedge clk); per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
    @(negedge clk); sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
    chk("R11 irq dropped", irq, 1'b0);
    rreg(8'd11, v); chk("R11 B enables cleared", v, 8'h12);
    rreg(8'd12, v); chk("R11 C flags cleared", v, 8'h00);

    finish_run();
  end
endmodule